// File: doc/BRIEF.md
# Masked Sticky Interrupt Aggregator

This block gathers a bank of level-sensitive interrupt request lines into one interrupt output for a processor. Each line has a bit in three registers. The enable mask is written by software. The sticky pending register holds a bit for every line that has been seen high. The line-level register holds a registered copy of the raw inputs. The output is high while some pending bit is also enabled in the mask.

Software acknowledges a pending bit by writing a one to that bit position of the pending register. Every cycle the pending register is refreshed from the live inputs after the acknowledge is applied. A line that is still held high therefore cannot be acknowledged away: it is pending again at once. As a debug aid, each line has a counter of its rising edges, which software can read through the same port as the other registers.

Top module: `irq_aggregator`

## Requirements
- R1: A synchronous active-high reset sets the mask, pending and line-level registers to zero. It also clears every edge counter, the read data and the interrupt output.
- R2: At each clock edge the line-level register takes the current input levels. A line that goes high sets its bit, and a line that goes low clears it.
- R3: At each clock edge every input that is high sets its pending bit. A pending bit stays set after its line goes low, until it is acknowledged.
- R4: A write to address 1 (pending) clears each pending bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0 unchanged.
- R5: The acknowledge is applied before the live levels are merged in. A bit acknowledged in the same cycle that its input is high stays set.
- R6: A write to address 0 replaces the whole mask with the write data. The registered output irq_out equals the OR of (pending AND mask) as those registers stood one clock earlier.
- R7: The counter of line n increases by one, modulo 2^CNT_W, on each cycle where that input is high and was low at the previous edge. A line held high for several cycles counts once.
- R8: Reads have one cycle of latency, and rdata reflects the address presented before the last clock edge. Address 0 returns the mask, address 1 the pending register and address 2 the line levels. An address with its top bit set returns counter n, where n is the lower address bits. Every other address returns zero.
- R9: Writes to the line-level address, to any counter address or to an unmapped address change no register. Only a mask write changes the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Level-sensitive request lines, synchronous to clk |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W | Register address (top bit selects counters) |
| wdata | input | NUM_LINES | Write data |
| rdata | output | NUM_LINES | Read data, one cycle after addr |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
The hardest case to reach is an acknowledge that lands in the same cycle as a still-high line. In that cycle the clear and the re-set of one pending bit compete. The bench holds a line high across an acknowledge write and reads the pending register back to show that the bit survived. It then drops the line and acknowledges again to show that the bit clears. A random phase then mixes line toggles with writes to every address. A cycle-accurate behavioural model is compared against irq_out and rdata on every clock. This catches any ordering error between clear and merge, and any skew in the one-cycle output and read delays.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Register selector produced by the address decoder
    typedef enum logic [2:0] {
        SEL_MASK = 3'd0,
        SEL_PEND = 3'd1,
        SEL_LVL  = 3'd2,
        SEL_CNT  = 3'd3,
        SEL_NONE = 3'd4
    } reg_sel_e;

    // Word offsets inside the register half of the address space
    localparam int unsigned OFS_MASK = 0;
    localparam int unsigned OFS_PEND = 1;
    localparam int unsigned OFS_LVL  = 2;

    // Decoded access, carried from decoder to state and read path
    typedef struct packed {
        reg_sel_e sel;
        logic     wr_mask;
        logic     wr_ack;
    } access_t;

    // Map a word offset to a register selector
    function automatic reg_sel_e offset_to_sel(input int unsigned ofs);
        case (ofs)
            OFS_MASK: offset_to_sel = SEL_MASK;
            OFS_PEND: offset_to_sel = SEL_PEND;
            OFS_LVL:  offset_to_sel = SEL_LVL;
            default:  offset_to_sel = SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
    import irq_agg_pkg::*;
#(
    parameter int unsigned ADDR_W = 6
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output access_t           acc,
    output logic [ADDR_W-2:0] cnt_idx
);
    localparam int unsigned IDX_W = ADDR_W - 1;

    logic      cnt_space;
    reg_sel_e  sel;

    assign cnt_space = addr[ADDR_W-1];
    assign cnt_idx   = addr[IDX_W-1:0];

    always_comb begin
        if (cnt_space) begin
            sel = SEL_CNT;
        end else begin
            sel = offset_to_sel(int'(addr[IDX_W-1:0]));
        end
    end

    always_comb begin
        acc.sel     = sel;
        acc.wr_mask = wr_en && (sel == SEL_MASK);
        acc.wr_ack  = wr_en && (sel == SEL_PEND);
    end
endmodule

// File: rtl/irq_agg_state.sv
module irq_agg_state #(
    parameter int unsigned NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 mask_we,
    input  logic                 ack_we,
    input  logic [NUM_LINES-1:0] wdata,
    output logic [NUM_LINES-1:0] mask_q,
    output logic [NUM_LINES-1:0] pend_q,
    output logic [NUM_LINES-1:0] lvl_q,
    output logic                 irq_q
);
    logic [NUM_LINES-1:0] ack_vec;
    logic [NUM_LINES-1:0] pend_d;

    // Clear first, then merge the live levels
    assign ack_vec = ack_we ? wdata : '0;
    assign pend_d  = (pend_q & ~ack_vec) | irq_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            pend_q <= '0;
            lvl_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (mask_we) begin
                mask_q <= wdata;
            end
            pend_q <= pend_d;
            lvl_q  <= irq_in;
            irq_q  <= |(pend_q & mask_q);
        end
    end
endmodule

// File: rtl/irq_agg_counters.sv
module irq_agg_counters #(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned CNT_W     = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_LINES-1:0]             irq_in,
    input  logic [NUM_LINES-1:0]             prev_lvl,
    output logic [NUM_LINES-1:0][CNT_W-1:0]  cnt
);
    logic [NUM_LINES-1:0] rise;

    assign rise = irq_in & ~prev_lvl;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[g] <= '0;
            end else if (rise[g]) begin
                cnt[g] <= cnt[g] + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned ADDR_W    = $clog2(NUM_LINES) + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_LINES-1:0] wdata,
    output logic [NUM_LINES-1:0] rdata,
    output logic                 irq_out
);
    localparam int unsigned IDX_W = ADDR_W - 1;

    access_t                             acc;
    logic [IDX_W-1:0]                    cnt_idx;
    logic [NUM_LINES-1:0]                mask_q;
    logic [NUM_LINES-1:0]                pend_q;
    logic [NUM_LINES-1:0]                lvl_q;
    logic [NUM_LINES-1:0][CNT_W-1:0]     cnt;
    logic [NUM_LINES-1:0]                rdata_d;
    logic [NUM_LINES-1:0]                rdata_q;
    logic [CNT_W-1:0]                    cnt_sel;

    irq_agg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_en   (wr_en),
        .addr    (addr),
        .acc     (acc),
        .cnt_idx (cnt_idx)
    );

    irq_agg_state #(.NUM_LINES(NUM_LINES)) u_state (
        .clk     (clk),
        .rst     (rst),
        .irq_in  (irq_in),
        .mask_we (acc.wr_mask),
        .ack_we  (acc.wr_ack),
        .wdata   (wdata),
        .mask_q  (mask_q),
        .pend_q  (pend_q),
        .lvl_q   (lvl_q),
        .irq_q   (irq_out)
    );

    irq_agg_counters #(.NUM_LINES(NUM_LINES), .CNT_W(CNT_W)) u_counters (
        .clk      (clk),
        .rst      (rst),
        .irq_in   (irq_in),
        .prev_lvl (lvl_q),
        .cnt      (cnt)
    );

    assign cnt_sel = cnt[cnt_idx];

    always_comb begin
        case (acc.sel)
            SEL_MASK: rdata_d = mask_q;
            SEL_PEND: rdata_d = pend_q;
            SEL_LVL:  rdata_d = lvl_q;
            SEL_CNT:  rdata_d = NUM_LINES'(cnt_sel);
            default:  rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker #(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned ADDR_W    = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINES-1:0] irq_in,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [NUM_LINES-1:0] wdata,
    input logic                 irq_out,
    input logic [NUM_LINES-1:0] mask_q,
    input logic [NUM_LINES-1:0] pend_q,
    input logic [NUM_LINES-1:0] lvl_q
);
    logic                 mask_wr;
    logic [NUM_LINES-1:0] ack_seen;

    assign mask_wr  = wr_en && (addr == ADDR_W'(0));
    assign ack_seen = (wr_en && (addr == ADDR_W'(1))) ? wdata : '0;

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (mask_q == '0 && pend_q == '0 && lvl_q == '0 && !irq_out));

    // R2
    a_r2_level_tracks: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (lvl_q == $past(irq_in)));

    // R3 and R4: only an acknowledge can drop a pending bit
    a_r3_pend_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(pend_q) & ~$past(ack_seen)) & ~pend_q) == '0));

    // R5: a high line is always pending after the edge
    a_r5_live_wins: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(irq_in) & ~pend_q) == '0));

    // R6
    a_r6_mask_write: assert property (@(posedge clk) disable iff (rst)
        mask_wr |=> (mask_q == $past(wdata)));

    a_r6_out_registered: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_out == |($past(pend_q & mask_q))));

    // R9
    a_r9_mask_hold: assert property (@(posedge clk) disable iff (rst)
        !mask_wr |=> $stable(mask_q));
endmodule

bind irq_aggregator irq_agg_checker #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
) u_checker (
    .clk     (clk),
    .rst     (rst),
    .irq_in  (irq_in),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .irq_out (irq_out),
    .mask_q  (mask_q),
    .pend_q  (pend_q),
    .lvl_q   (lvl_q)
);

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;
    localparam int N  = 32;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_in = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [N-1:0]  wdata = '0;
    logic [N-1:0]  rdata;
    logic          irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    irq_aggregator i_irq_aggregator (
        .clk     (clk),
        .rst     (rst),
        .irq_in  (irq_in),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq_out (irq_out)
    );

    // Behavioural reference model
    logic [31:0] m_mask, m_pend, m_lvl, m_rdata;
    logic        m_out;
    int unsigned m_cnt [N];

    function automatic logic [31:0] m_read(input int a);
        if (a >= 32)      return m_cnt[a - 32];
        else if (a == 0)  return m_mask;
        else if (a == 1)  return m_pend;
        else if (a == 2)  return m_lvl;
        else              return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mask <= '0; m_pend <= '0; m_lvl <= '0; m_rdata <= '0; m_out <= 1'b0;
            for (int i = 0; i < N; i++) m_cnt[i] <= 0;
        end else begin
            logic [31:0] ack;
            ack = (wr_en && addr == 1) ? wdata : 32'h0;
            m_rdata <= m_read(int'(addr));
            if (wr_en && addr == 0) m_mask <= wdata;
            m_pend <= (m_pend & ~ack) | irq_in;
            m_lvl  <= irq_in;
            m_out  <= |(m_pend & m_mask);
            for (int i = 0; i < N; i++)
                if (irq_in[i] && !m_lvl[i]) m_cnt[i] <= m_cnt[i] + 1;
        end
    end

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            n_checks++;
            if (irq_out !== m_out) begin
                n_fail++;
                $display("FAIL R6 model irq_out actual=%0b expected=%0b", irq_out, m_out);
            end
            n_checks++;
            if (rdata !== m_rdata) begin
                n_fail++;
                $display("FAIL R8 model rdata actual=%08h expected=%08h", rdata, m_rdata);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic do_write(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic do_read(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        wr_en = 1'b0; addr = AW'(a);
        @(negedge clk);
        chk(tag, rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle(4);
        @(negedge clk) rst = 1'b0;
        // R1: everything reads zero after reset
        chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
        chk("R1 rdata", rdata, 32'h0);
        do_read(0,  32'h0, "R1 mask");
        do_read(1,  32'h0, "R1 pending");
        do_read(2,  32'h0, "R1 level");
        do_read(37, 32'h0, "R1 counter5");

        // R2, R3: lines 0 and 4 go high
        @(negedge clk) irq_in = 32'h0000_0011;
        idle(2);
        do_read(2, 32'h0000_0011, "R2 level high");
        do_read(1, 32'h0000_0011, "R3 pending set");
        @(negedge clk) irq_in = '0;
        idle(2);
        do_read(2, 32'h0, "R2 level low");
        do_read(1, 32'h0000_0011, "R3 pending sticky");
        chk("R6 masked off", {31'b0, irq_out}, 32'h0);

        // R6: enabling line 4 raises the output one cycle after the mask
        do_write(0, 32'h0000_0010);
        chk("R6 output delayed", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        chk("R6 output raised", {31'b0, irq_out}, 32'h1);
        do_read(0, 32'h0000_0010, "R6 mask replaced");

        // R4: acknowledge line 4 only
        do_write(1, 32'h0000_0010);
        @(negedge clk);
        chk("R4 output dropped", {31'b0, irq_out}, 32'h0);
        do_read(1, 32'h0000_0001, "R4 ack clears ones only");

        // R5: acknowledge while line 8 is still high
        @(negedge clk) irq_in = 32'h0000_0100;
        idle(2);
        do_write(1, 32'h0000_0100);
        do_read(1, 32'h0000_0101, "R5 ack loses to live line");
        @(negedge clk) irq_in = '0;
        idle(1);
        do_write(1, 32'h0000_0101);
        do_read(1, 32'h0, "R4 ack after release");

        // R7: edge counting
        @(negedge clk) irq_in = 32'h0000_0008;
        idle(3);
        @(negedge clk) irq_in = '0;
        idle(2);
        @(negedge clk) irq_in = 32'h0000_0008;
        @(negedge clk) irq_in = '0;
        idle(1);
        do_read(35, 32'd2, "R7 counter3 held line counts once");
        do_read(40, 32'd1, "R7 counter8");
        do_read(32, 32'd1, "R7 counter0");
        do_read(33, 32'd0, "R7 counter1 idle");

        // R9: ignored writes
        do_write(2, 32'hFFFF_FFFF);
        do_read(2, 32'h0, "R9 level not writable");
        do_write(35, 32'h0);
        do_read(35, 32'd2, "R9 counter not writable");
        do_write(5, 32'h0000_DEAD);
        do_read(0, 32'h0000_0010, "R9 unmapped write keeps mask");
        do_read(5, 32'h0, "R8 unmapped reads zero");

        // Mixed traffic, compared against the model every cycle
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (($urandom % 4) == 0) irq_in = $urandom & $urandom;
            addr  = AW'($urandom);
            wdata = $urandom;
            wr_en = (($urandom % 3) == 0);
        end
        @(negedge clk) wr_en = 1'b0;
        idle(3);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule